// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block produces the serial-clock waveform for a two-wire bus master. It derives the low and high phase durations from the system clock. A single configuration word carries a separate mantissa for each phase and one shared power-of-two prescale exponent. A phase lasts the mantissa shifted left by the exponent, plus a fixed offset that is set at build time.

The master engine controls the block with run and stop pulses. In return the block reports phase progress on three one-cycle strobes. The drive strobe falls in the middle of each low phase, where the engine may change the data line. The sample strobe falls in the middle of each high phase, where the engine reads the data line. The advance strobe falls on the last cycle of every phase.

Configuration is taken only at the start of a low phase. Reprogramming therefore never distorts a phase that is already running. Clock stretching, programmable data hold and the conversion from a target bit rate into divider values are all left to other logic.

Top module: `scl_clock_gen`

## Requirements
- R1: The configuration word holds the low mantissa in bits 7:0, the high mantissa in bits 15:8 and the prescale exponent in bits 18:16.
- R2: Every low phase keeps `scl_o` at 0 for exactly low_mantissa × 2^exponent + OFFSET system clocks.
- R3: Every high phase within a run keeps `scl_o` at 1 for exactly high_mantissa × 2^exponent + OFFSET system clocks.
- R4: An exponent above CKDIV_MAX is used as CKDIV_MAX.
- R5: The configuration word is sampled only on the cycle that begins a low phase. A change during a phase affects neither that phase nor the high phase that follows it.
- R6: While idle, `scl_o` is 1, `busy_o` is 0 and all strobes are 0. A `run_i` pulse in idle starts a full-length low phase on the next cycle.
- R7: A `run_i` pulse while busy has no effect on the phase lengths.
- R8: A `stop_i` pulse while busy lets the current low phase, if any, finish, then the following high phase. The block then goes idle with `scl_o` at 1. A `stop_i` pulse while idle has no effect.
- R9: Each low phase of length L gives exactly one `drive_stb_o` pulse, on cycle ceil(L/2)−1 counted from 0 at the phase start.
- R10: Each high phase of length L gives exactly one `sample_stb_o` pulse, on cycle ceil(L/2)−1 of that phase.
- R11: `adv_stb_o` pulses exactly once per phase, on its last cycle (cycle L−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| timing_cfg_i | input | 19 | Mantissas and prescale exponent (R1 layout) |
| run_i | input | 1 | Start pulse from the master engine |
| stop_i | input | 1 | Stop pulse from the master engine |
| scl_o | output | 1 | Serial clock level, 1 = released high |
| busy_o | output | 1 | A run is in progress |
| drive_stb_o | output | 1 | Mid-low strobe for changing the data line |
| sample_stb_o | output | 1 | Mid-high strobe for sampling the data line |
| adv_stb_o | output | 1 | Last cycle of the current phase |

## Verification
The assertions check every cycle for properties that hold regardless of timing values:
- the idle state is quiet;
- a run pulse lands in a low phase;
- `scl_o` moves only on an advance strobe;
- the drive and sample strobes fall only in their own phase level.

The exact phase lengths, exponent clamping, the mid-strobe positions and the deferred pickup of a new configuration depend on the programmed values. Only the bench's scenarios can show these, by counting cycles between level changes. The same applies to stop completing a full high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    localparam int MANT_W  = 8;
    localparam int EXP_W   = 3;
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = 8;
    localparam int EXP_LSB = 16;
    localparam int CFG_W   = EXP_LSB + EXP_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;
endpackage

// File: rtl/scl_cfg_unpack.sv
module scl_cfg_unpack
    import scl_gen_pkg::*;
#(
    parameter int OFFSET    = 4,
    parameter int CKDIV_MAX = 5,
    parameter int CNT_W     = 13
) (
    input  logic [CFG_W-1:0] cfg_i,
    output logic [CNT_W-1:0] len_lo_o,
    output logic [CNT_W-1:0] len_hi_o
);
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(CKDIV_MAX);
    localparam logic [CNT_W-1:0] OFF_C   = CNT_W'(OFFSET);
    localparam int               LSB_TAB [2] = '{LO_LSB, HI_LSB};

    logic [EXP_W-1:0]  exp_raw;
    logic [EXP_W-1:0]  exp_eff;
    logic [MANT_W-1:0] mant [2];
    logic [CNT_W-1:0]  len  [2];

    assign exp_raw = cfg_i[EXP_LSB +: EXP_W];
    // exponent saturates at the build-time cap
    assign exp_eff = (exp_raw > EXP_CAP) ? EXP_CAP : exp_raw;

    for (genvar g = 0; g < 2; g++) begin : g_len
        assign mant[g] = cfg_i[LSB_TAB[g] +: MANT_W];
        assign len[g]  = (CNT_W'(mant[g]) << exp_eff) + OFF_C;
    end

    assign len_lo_o = len[0];
    assign len_hi_o = len[1];
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] len_lo_i,
    input  logic [CNT_W-1:0] len_hi_i,
    output logic             scl_o,
    output logic             busy_o,
    output logic             drive_stb_o,
    output logic             sample_stb_o,
    output logic             adv_stb_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        scl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lo_len;
        logic [CNT_W-1:0] hi_len;
        logic             stop_pend;
    } ctl_state_t;

    localparam ctl_state_t RST_VAL = '{
        ph: PH_IDLE, cnt: '0, lo_len: '0, hi_len: '0, stop_pend: 1'b0
    };

    ctl_state_t st_d, st_q;
    logic       last_c;
    logic       pend_c;

    assign last_c = (st_q.cnt == '0);

    always_comb begin
        st_d   = st_q;
        pend_c = st_q.stop_pend | stop_i;
        unique case (st_q.ph)
            PH_IDLE: begin
                st_d.cnt       = '0;
                st_d.stop_pend = 1'b0;
                if (run_i) begin
                    st_d.ph     = PH_LOW;
                    st_d.lo_len = len_lo_i;
                    st_d.hi_len = len_hi_i;
                    st_d.cnt    = len_lo_i - ONE;
                end
            end
            PH_LOW: begin
                st_d.stop_pend = pend_c;
                if (last_c) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = st_q.hi_len - ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_HIGH: begin
                st_d.stop_pend = pend_c;
                if (last_c) begin
                    if (pend_c) begin
                        st_d = RST_VAL;
                    end else begin
                        // new timing is taken only here
                        st_d.ph     = PH_LOW;
                        st_d.lo_len = len_lo_i;
                        st_d.hi_len = len_hi_i;
                        st_d.cnt    = len_lo_i - ONE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            default: st_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_VAL;
        else         st_q <= st_d;
    end

    assign busy_o       = (st_q.ph != PH_IDLE);
    assign scl_o        = (st_q.ph != PH_LOW);
    assign adv_stb_o    = busy_o && last_c;
    assign drive_stb_o  = (st_q.ph == PH_LOW)  && (st_q.cnt == (st_q.lo_len >> 1));
    assign sample_stb_o = (st_q.ph == PH_HIGH) && (st_q.cnt == (st_q.hi_len >> 1));
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int OFFSET    = 4,
    parameter int CKDIV_MAX = 5
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [scl_gen_pkg::CFG_W-1:0] timing_cfg_i,
    input  logic                         run_i,
    input  logic                         stop_i,
    output logic                         scl_o,
    output logic                         busy_o,
    output logic                         drive_stb_o,
    output logic                         sample_stb_o,
    output logic                         adv_stb_o
);
    localparam int LEN_MAX = ((2 ** scl_gen_pkg::MANT_W) - 1) * (2 ** CKDIV_MAX) + OFFSET;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic [CNT_W-1:0] len_lo;
    logic [CNT_W-1:0] len_hi;

    scl_cfg_unpack #(
        .OFFSET   (OFFSET),
        .CKDIV_MAX(CKDIV_MAX),
        .CNT_W    (CNT_W)
    ) u_unpack (
        .cfg_i   (timing_cfg_i),
        .len_lo_o(len_lo),
        .len_hi_o(len_hi)
    );

    scl_phase_ctl #(
        .CNT_W(CNT_W)
    ) u_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_i),
        .stop_i      (stop_i),
        .len_lo_i    (len_lo),
        .len_hi_i    (len_hi),
        .scl_o       (scl_o),
        .busy_o      (busy_o),
        .drive_stb_o (drive_stb_o),
        .sample_stb_o(sample_stb_o),
        .adv_stb_o   (adv_stb_o)
    );
endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic run_i,
    input logic scl_o,
    input logic busy_o,
    input logic drive_stb_o,
    input logic sample_stb_o,
    input logic adv_stb_o
);
    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (scl_o && !drive_stb_o && !sample_stb_o && !adv_stb_o));

    p_run_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && run_i) |=> (busy_o && !scl_o));

    p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !run_i) |=> !busy_o);

    p_scl_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !adv_stb_o) |=> $stable(scl_o));

    p_low_ends_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && adv_stb_o && !scl_o) |=> (busy_o && scl_o));

    p_drive_in_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_stb_o |-> (busy_o && !scl_o));

    p_sample_in_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_o |-> (busy_o && scl_o));
endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .scl_o       (scl_o),
    .busy_o      (busy_o),
    .drive_stb_o (drive_stb_o),
    .sample_stb_o(sample_stb_o),
    .adv_stb_o   (adv_stb_o)
);

// File: tb/scl_clock_gen_bench.sv
`timescale 1ns/1ps
module scl_clock_gen_bench;
    localparam int OFFSET    = 4;
    localparam int CKDIV_MAX = 5;
    localparam int LIMIT     = 10000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [18:0] timing_cfg_i = '0;
    logic        run_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        scl_o, busy_o, drive_stb_o, sample_stb_o, adv_stb_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    scl_clock_gen #(.OFFSET(OFFSET), .CKDIV_MAX(CKDIV_MAX)) u_scl_clock_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .timing_cfg_i(timing_cfg_i),
        .run_i(run_i), .stop_i(stop_i), .scl_o(scl_o), .busy_o(busy_o),
        .drive_stb_o(drive_stb_o), .sample_stb_o(sample_stb_o),
        .adv_stb_o(adv_stb_o)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R1 field layout: exponent 18:16, high mantissa 15:8, low mantissa 7:0
    function automatic logic [18:0] mk_cfg(input int lo, input int hi, input int e);
        return {e[2:0], hi[7:0], lo[7:0]};
    endfunction

    function automatic int exp_len(input int mant, input int e);
        int ee = (e > CKDIV_MAX) ? CKDIV_MAX : e;
        return mant * (1 << ee) + OFFSET;
    endfunction

    // Called at the negedge of the first cycle of a phase; returns at the
    // negedge of the first cycle after it.
    task automatic check_phase(input logic lvl, input int len, input string req);
        int n = 0, dpos = -1, spos = -1, apos = -1, dcnt = 0, scnt = 0, acnt = 0;
        int mid = (len + 1) / 2 - 1;
        while (scl_o == lvl && busy_o && n < LIMIT) begin
            if (drive_stb_o)  begin dcnt++; dpos = n; end
            if (sample_stb_o) begin scnt++; spos = n; end
            if (adv_stb_o)    begin acnt++; apos = n; end
            n++;
            @(negedge clk_i);
            run_i  = 1'b0;
            stop_i = 1'b0;
        end
        check_eq(req, lvl ? "high length" : "low length", n, len);
        if (!lvl) begin
            check_eq("R9", "drive count", dcnt, 1);
            check_eq("R9", "drive position", dpos, mid);
            check_eq("R10", "sample count in low", scnt, 0);
        end else begin
            check_eq("R10", "sample count", scnt, 1);
            check_eq("R10", "sample position", spos, mid);
            check_eq("R9", "drive count in high", dcnt, 0);
        end
        check_eq("R11", "adv count", acnt, 1);
        check_eq("R11", "adv position", apos, len - 1);
    endtask

    task automatic start_run(input logic [18:0] cfg, input bit stop_first, input bit rerun_first);
        @(negedge clk_i);
        timing_cfg_i = cfg;
        run_i = 1'b1;
        @(negedge clk_i);
        run_i  = rerun_first;
        stop_i = stop_first;
        check_eq("R6", "busy after run", int'(busy_o), 1);
    endtask

    task automatic end_run();
        int n = 0;
        stop_i = 1'b1;
        @(negedge clk_i);
        stop_i = 1'b0;
        while (busy_o && n < LIMIT) begin n++; @(negedge clk_i); end
    endtask

    task automatic check_idle(input string req, input int cycles);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            if (!scl_o || busy_o || drive_stb_o || sample_stb_o || adv_stb_o) bad++;
            @(negedge clk_i);
        end
        check_eq(req, "idle violations", bad, 0);
    endtask

    task automatic t_reset();
        check_idle("R6", 4);
        timing_cfg_i = mk_cfg(3, 3, 0);
        check_idle("R6", 10);
    endtask

    task automatic t_symmetric();
        start_run(mk_cfg(10, 10, 0), 1'b0, 1'b0);
        check_phase(1'b0, exp_len(10, 0), "R1/R2");
        check_phase(1'b1, exp_len(10, 0), "R1/R3");
        check_phase(1'b0, exp_len(10, 0), "R2");
        end_run();
    endtask

    task automatic t_asym();
        start_run(mk_cfg(5, 20, 2), 1'b0, 1'b0);
        check_phase(1'b0, exp_len(5, 2), "R1/R2");
        check_phase(1'b1, exp_len(20, 2), "R1/R3");
        end_run();
    endtask

    task automatic t_clamp();
        start_run(mk_cfg(2, 1, 7), 1'b0, 1'b0);
        check_phase(1'b0, 2 * 32 + OFFSET, "R4");
        check_phase(1'b1, 1 * 32 + OFFSET, "R4");
        end_run();
    endtask

    task automatic t_zero_mant();
        start_run(mk_cfg(0, 0, 3), 1'b0, 1'b0);
        check_phase(1'b0, OFFSET, "R2");
        check_phase(1'b1, OFFSET, "R3");
        end_run();
    endtask

    task automatic t_cfg_switch();
        start_run(mk_cfg(6, 6, 0), 1'b0, 1'b0);
        timing_cfg_i = mk_cfg(2, 5, 1);
        check_phase(1'b0, exp_len(6, 0), "R5");
        check_phase(1'b1, exp_len(6, 0), "R5");
        check_phase(1'b0, exp_len(2, 1), "R5");
        check_phase(1'b1, exp_len(5, 1), "R5");
        end_run();
    endtask

    task automatic t_stop();
        start_run(mk_cfg(10, 10, 0), 1'b1, 1'b0);
        check_phase(1'b0, exp_len(10, 0), "R8");
        check_phase(1'b1, exp_len(10, 0), "R8");
        check_idle("R8", 20);
    endtask

    task automatic t_rerun();
        start_run(mk_cfg(8, 9, 1), 1'b0, 1'b1);
        check_phase(1'b0, exp_len(8, 1), "R7");
        run_i = 1'b1;
        check_phase(1'b1, exp_len(9, 1), "R7");
        end_run();
    endtask

    task automatic t_idle_stop();
        @(negedge clk_i);
        stop_i = 1'b1;
        @(negedge clk_i);
        stop_i = 1'b0;
        check_idle("R8", 3);
        start_run(mk_cfg(10, 10, 0), 1'b0, 1'b0);
        check_phase(1'b0, exp_len(10, 0), "R8");
        check_phase(1'b1, exp_len(10, 0), "R8");
        check_eq("R8", "run continues after high", int'(busy_o && !scl_o), 1);
        end_run();
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_symmetric();
        t_asym();
        t_clamp();
        t_zero_mant();
        t_cfg_switch();
        t_stop();
        t_rerun();
        t_idle_stop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule